// File: doc/BRIEF.md
# Tagged Memory-Fill Sequencer

This engine fills a destination range with one repeated byte and, for each 16-byte granule it stores, also writes a 4-bit allocation tag. The tag is taken from a fixed logical-tag field of the address being written. Software runs a fill as three stages in a fixed order: prologue, then main, then epilogue. Each stage is one command. The command carries the stage code, an address, a size, the fill byte, the algorithm choice and a four-bit flag word. When the stage finishes, the engine returns the updated address, size and flags. These values are fed into the next stage, or into a retry of the same stage after a fault.

The two algorithms count in opposite directions. Under algorithm A, the prologue turns the pair into an end pointer and a negated size. Every write then targets end pointer plus size, and the size climbs toward zero. Under algorithm B, the address climbs and the size falls. The prologue never writes memory. The main stage writes at most a fixed number of granules. The epilogue writes whatever remains.

Each write is one handshake on a combined data-and-tag port. The cycle after each write carries separate error flags for the data store and the tag store. After an error, the engine stops, and the returned address and size count only the granules that completed.

Top module: `tagFillEngine`

## Requirements
- R1: Every accepted write carries sixteen copies of `fillByte` on `wrData`. Its `wrTag` equals bits [TAG_LSB+3:TAG_LSB] of that write's `wrAddr`.
- R2: The stage code on `stageSel` is 0 for prologue, 1 for main and 2 for epilogue. Code 3 behaves as epilogue. The prologue reads the size as unsigned and clamps it to MAX_SIZE.
- R3: A prologue fails with fault code 1 (alignment) in either of two cases: the size is not a multiple of 16, or the size is nonzero and the address is not a multiple of 16. The fault address is the input address and the flags are unchanged.
- R4: A successful prologue under algorithm A (`algoB`=0) returns flags 0000, address plus size, and the negated size. Under algorithm B it returns flags 0010 (bit 1 is the carry), the address unchanged and the clamped size. It never writes.
- R5: In main or epilogue, algorithm A writes at address plus size and raises the size by 16 per granule. Algorithm B writes at the address, raises it by 16 and lowers the size by 16.
- R6: A main stage writes the smaller of the remaining granules and MAIN_BUDGET. An epilogue writes every remaining granule.
- R7: In main or epilogue, a carry flag (bit 1) that differs from `algoB` gives fault code 4. Nothing is written, and the fault address is the input address.
- R8: In main or epilogue, a nonzero size with a misaligned address or size gives fault code 1 with no writes. The fault address is address plus size under A, and the address under B.
- R9: A data error in the response cycle gives code 2. A tag error alone gives code 3, and a data error wins if both are set. The fault address is that write's address, the engine stops, and address and size count only earlier granules.
- R10: `wrValid` stays high with a stable address until `wrReady`. The error response is sampled in the cycle after the handshake, and no write is issued in that cycle.
- R11: A zero size in any stage, or a main/epilogue size whose sign gives no work under the chosen algorithm, completes with no write and no fault.
- R12: Main and epilogue return the flags unchanged. `busy` is high from the cycle after `start` through `done`. `done` is a one-cycle pulse, and after reset the engine is idle with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a stage while idle |
| stageSel | input | 2 | Stage code |
| algoB | input | 1 | 1 selects the down-counting algorithm |
| addrIn | input | ADDR_W | Address operand |
| sizeIn | input | ADDR_W | Size operand |
| fillByte | input | 8 | Low byte of the source operand |
| flagsIn | input | 4 | Flag word, bit 1 is carry |
| busy | output | 1 | Stage in progress |
| done | output | 1 | Stage finished, results valid |
| addrOut | output | ADDR_W | Updated address |
| sizeOut | output | ADDR_W | Updated size |
| flagsOut | output | 4 | Updated flags |
| fault | output | 1 | Stage ended on a fault |
| faultCode | output | 3 | 1 alignment, 2 data, 3 tag, 4 flag mismatch |
| faultAddr | output | ADDR_W | Address reported with the fault |
| wrValid | output | 1 | Write request |
| wrReady | input | 1 | Write accepted |
| wrAddr | output | ADDR_W | Granule address |
| wrData | output | 128 | Granule data |
| wrTag | output | 4 | Allocation tag |
| dataErr | input | 1 | Data store error, cycle after handshake |
| tagErr | input | 1 | Tag store error, cycle after handshake |

## Verification
The data-store error and the tag-store error can arrive in the same response cycle. The bench provokes this by raising both flags on a chosen granule of a main stage. It then checks that code 2 is reported, that the fault address is that granule's address, and that address and size moved only by the granules written before it. Granule advance and fault capture are also tested against each other. Errors are injected at several positions and the stage is resumed from the returned state. The bench checks that the resumed run writes exactly the remaining granules.

// File: rtl/tagFillPkg.sv
package tagFillPkg;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_ALIGN = 3'd1,
    FC_DATA  = 3'd2,
    FC_TAG   = 3'd3,
    FC_FLAG  = 3'd4
  } faultCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       prolDone;
    logic       step;
    logic       raise;
    faultCode_t code;
  } ctrlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic isPro;
    logic alignBad;
    logic carryBad;
    logic anyLeft;
    logic lastLeft;
  } dpStatus_t;

endpackage

// File: rtl/tagFillDatapath.sv
module tagFillDatapath
  import tagFillPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_SIZE    = 1024,
  parameter int MAIN_BUDGET = 4,
  parameter int TAG_LSB     = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  input  logic [1:0]        stageIn,
  input  logic              algoBIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] sizeIn,
  input  logic [7:0]        fillIn,
  input  logic [3:0]        flagsIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] sizeOut,
  output logic [3:0]        flagsOut,
  output logic              faultOut,
  output faultCode_t        faultCodeOut,
  output logic [ADDR_W-1:0] faultAddrOut,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [127:0]      wrData,
  output logic [3:0]        wrTag
);

  localparam int GRAN_BYTES = 16;
  localparam int GRAN_SHIFT = 4;
  localparam int LEFT_W     = ADDR_W - GRAN_SHIFT;
  localparam logic [ADDR_W-1:0] GRAN_VEC = ADDR_W'(GRAN_BYTES);
  localparam logic [ADDR_W-1:0] MAX_VEC  = ADDR_W'(MAX_SIZE);
  localparam logic [LEFT_W-1:0] BUDGET_VEC = LEFT_W'(MAIN_BUDGET);
  localparam logic [3:0] FLAGS_A = 4'b0000;
  localparam logic [3:0] FLAGS_B = 4'b0010;

  logic [ADDR_W-1:0] addrReg, sizeReg, faultAddrReg;
  logic [3:0]        flagsReg;
  logic [7:0]        fillReg;
  logic              algoBReg, proReg, faultReg;
  faultCode_t        codeReg;
  logic [LEFT_W-1:0] leftReg;

  // operand conditioning at load time
  logic              isProN, isMainN;
  logic [ADDR_W-1:0] clampSize, negSize;
  logic [LEFT_W-1:0] availGran, stageGran;

  always_comb begin
    isProN    = (stageIn == 2'd0);
    isMainN   = (stageIn == 2'd1);
    clampSize = (isProN && (sizeIn > MAX_VEC)) ? MAX_VEC : sizeIn;
    negSize   = -sizeIn;
    if (algoBIn)
      availGran = sizeIn[ADDR_W-1] ? '0 : sizeIn[ADDR_W-1:GRAN_SHIFT];
    else
      availGran = sizeIn[ADDR_W-1] ? negSize[ADDR_W-1:GRAN_SHIFT] : '0;
    stageGran = (isMainN && (availGran > BUDGET_VEC)) ? BUDGET_VEC : availGran;
  end

  // write port
  always_comb begin
    wrAddr = algoBReg ? addrReg : (addrReg + sizeReg);
    wrData = {GRAN_BYTES{fillReg}};
    wrTag  = wrAddr[TAG_LSB +: 4];
  end

  // status toward control
  always_comb begin
    status.isPro    = proReg;
    status.alignBad = (sizeReg != '0) &&
                      ((addrReg[GRAN_SHIFT-1:0] != '0) || (sizeReg[GRAN_SHIFT-1:0] != '0));
    status.carryBad = (flagsReg[1] != algoBReg);
    status.anyLeft  = (leftReg != '0);
    status.lastLeft = (leftReg == LEFT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg      <= '0;
      sizeReg      <= '0;
      flagsReg     <= '0;
      fillReg      <= '0;
      algoBReg     <= 1'b0;
      proReg       <= 1'b0;
      leftReg      <= '0;
      faultReg     <= 1'b0;
      codeReg      <= FC_NONE;
      faultAddrReg <= '0;
    end else begin
      if (strobe.load) begin
        addrReg      <= addrIn;
        sizeReg      <= clampSize;
        flagsReg     <= flagsIn;
        fillReg      <= fillIn;
        algoBReg     <= algoBIn;
        proReg       <= isProN;
        leftReg      <= stageGran;
        faultReg     <= 1'b0;
        codeReg      <= FC_NONE;
        faultAddrReg <= '0;
      end
      if (strobe.prolDone) begin
        if (algoBReg) begin
          flagsReg <= FLAGS_B;
        end else begin
          flagsReg <= FLAGS_A;
          addrReg  <= addrReg + sizeReg;
          sizeReg  <= -sizeReg;
        end
      end
      if (strobe.step) begin
        leftReg <= leftReg - LEFT_W'(1);
        if (algoBReg) begin
          addrReg <= addrReg + GRAN_VEC;
          sizeReg <= sizeReg - GRAN_VEC;
        end else begin
          sizeReg <= sizeReg + GRAN_VEC;
        end
      end
      if (strobe.raise) begin
        faultReg     <= 1'b1;
        codeReg      <= strobe.code;
        faultAddrReg <= ((strobe.code == FC_FLAG) || proReg) ? addrReg : wrAddr;
      end
    end
  end

  assign addrOut      = addrReg;
  assign sizeOut      = sizeReg;
  assign flagsOut     = flagsReg;
  assign faultOut     = faultReg;
  assign faultCodeOut = codeReg;
  assign faultAddrOut = faultAddrReg;

  // a step never goes past the granules granted to the stage
  a_r6_step_within_stage: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (leftReg != '0));

  // the prologue never issues a granule step
  a_r4_prologue_no_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load) |-> !proReg);

endmodule

// File: rtl/tagFillCtrl.sv
module tagFillCtrl
  import tagFillPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  input  logic        wrReady,
  input  logic        dataErr,
  input  logic        tagErr,
  output ctrlStrobe_t strobe,
  output logic        wrValid,
  output logic        busy,
  output logic        done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_ISSUE, ST_RESP, ST_FINISH
  } ctrlState_t;

  ctrlState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        nextState = ST_FINISH;
        if (status.isPro) begin
          if (status.alignBad) begin
            strobe.raise = 1'b1;
            strobe.code  = FC_ALIGN;
          end else begin
            strobe.prolDone = 1'b1;
          end
        end else if (status.carryBad) begin
          strobe.raise = 1'b1;
          strobe.code  = FC_FLAG;
        end else if (status.alignBad) begin
          strobe.raise = 1'b1;
          strobe.code  = FC_ALIGN;
        end else if (status.anyLeft) begin
          nextState = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (wrReady) nextState = ST_RESP;
      end
      ST_RESP: begin
        if (dataErr) begin
          strobe.raise = 1'b1;
          strobe.code  = FC_DATA;
          nextState    = ST_FINISH;
        end else if (tagErr) begin
          strobe.raise = 1'b1;
          strobe.code  = FC_TAG;
          nextState    = ST_FINISH;
        end else begin
          strobe.step = 1'b1;
          nextState   = status.lastLeft ? ST_FINISH : ST_ISSUE;
        end
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign wrValid = (state == ST_ISSUE);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FINISH);

  // no new request in the response cycle
  a_r10_resp_gap: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |=> !wrValid);

  // a fault and a granule advance never share a cycle
  a_r9_fault_stops: assert property (@(posedge clk) disable iff (!rstN)
    strobe.raise |-> !strobe.step);

endmodule

// File: rtl/tagFillEngine.sv
module tagFillEngine
  import tagFillPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_SIZE    = 1024,
  parameter int MAIN_BUDGET = 4,
  parameter int TAG_LSB     = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        stageSel,
  input  logic              algoB,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] sizeIn,
  input  logic [7:0]        fillByte,
  input  logic [3:0]        flagsIn,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] sizeOut,
  output logic [3:0]        flagsOut,
  output logic              fault,
  output logic [2:0]        faultCode,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [127:0]      wrData,
  output logic [3:0]        wrTag,
  input  logic              dataErr,
  input  logic              tagErr
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  faultCode_t  codeW;

  tagFillCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .status  (status),
    .wrReady (wrReady),
    .dataErr (dataErr),
    .tagErr  (tagErr),
    .strobe  (strobe),
    .wrValid (wrValid),
    .busy    (busy),
    .done    (done)
  );

  tagFillDatapath #(
    .ADDR_W      (ADDR_W),
    .MAX_SIZE    (MAX_SIZE),
    .MAIN_BUDGET (MAIN_BUDGET),
    .TAG_LSB     (TAG_LSB)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .status       (status),
    .stageIn      (stageSel),
    .algoBIn      (algoB),
    .addrIn       (addrIn),
    .sizeIn       (sizeIn),
    .fillIn       (fillByte),
    .flagsIn      (flagsIn),
    .addrOut      (addrOut),
    .sizeOut      (sizeOut),
    .flagsOut     (flagsOut),
    .faultOut     (fault),
    .faultCodeOut (codeW),
    .faultAddrOut (faultAddr),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .wrTag        (wrTag)
  );

  assign faultCode = codeW;

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr)));

  a_r5_granule_aligned: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrAddr[3:0] == 4'd0));

  a_r9_code_with_fault: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (faultCode != 3'd0));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: tb/tagFillEngine_tb_top.sv
module tagFillEngine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXS   = 1024;
  localparam int BUDGET = 4;

  logic clk = 1'b0;
  logic rstN;
  logic start;
  logic [1:0] stageSel;
  logic algoB;
  logic [31:0] addrIn, sizeIn;
  logic [7:0] fillByte;
  logic [3:0] flagsIn;
  logic busy, done, fault, wrValid, wrReady, dataErr, tagErr;
  logic [31:0] addrOut, sizeOut, faultAddr, wrAddr;
  logic [3:0] flagsOut, wrTag;
  logic [2:0] faultCode;
  logic [127:0] wrData;

  int nChecks = 0;
  int nFails  = 0;

  // responder state
  logic [31:0]  wA [64];
  logic [127:0] wD [64];
  logic [3:0]   wT [64];
  int wN = 0;
  int curErrAt = -1;
  logic [1:0] curErrKind = 2'b00;
  int readyMode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagFillEngine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .stageSel(stageSel), .algoB(algoB),
    .addrIn(addrIn), .sizeIn(sizeIn), .fillByte(fillByte), .flagsIn(flagsIn),
    .busy(busy), .done(done), .addrOut(addrOut), .sizeOut(sizeOut),
    .flagsOut(flagsOut), .fault(fault), .faultCode(faultCode),
    .faultAddr(faultAddr), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .wrTag(wrTag),
    .dataErr(dataErr), .tagErr(tagErr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder: decides ready and error flags at each falling edge
  initial begin
    int readyCnt;
    logic pend;
    logic [1:0] pendKind;
    readyCnt = 0; pend = 1'b0; pendKind = 2'b00;
    wrReady = 1'b0; dataErr = 1'b0; tagErr = 1'b0;
    forever begin
      @(negedge clk);
      dataErr = pend & pendKind[0];
      tagErr  = pend & pendKind[1];
      pend = 1'b0;
      readyCnt++;
      wrReady = (readyMode == 0) ? 1'b1 : ((readyCnt % 3) == 0);
      if (wrValid && wrReady) begin
        if (wN < 64) begin
          wA[wN] = wrAddr; wD[wN] = wrData; wT[wN] = wrTag;
        end
        pend = 1'b1;
        pendKind = (wN == curErrAt) ? curErrKind : 2'b00;
        wN++;
      end
    end
  end

  task automatic runOp(input logic [1:0] stg, input logic [31:0] a,
                       input logic [31:0] s, input logic ob,
                       input logic [3:0] fl, input int errAt,
                       input logic [1:0] errKind, input string req);
    logic [31:0] eA, eS, eFA, sz, wa;
    logic [3:0]  eF;
    logic        eFault;
    logic [2:0]  eCode;
    logic [31:0] expWA [64];
    int eN, left, cyc;
    bit wOk;
    eFault = 1'b0; eCode = 3'd0; eFA = '0; eN = 0;
    // expected behaviour from the requirements
    if (stg == 2'd0) begin
      sz = (s > 32'(MAXS)) ? 32'(MAXS) : s;
      eA = a; eS = sz; eF = fl;
      if ((sz != 0 && a[3:0] != 0) || sz[3:0] != 0) begin
        eFault = 1'b1; eCode = 3'd1; eFA = a;
      end else if (!ob) begin
        eA = a + sz; eS = -sz; eF = 4'b0000;
      end else begin
        eF = 4'b0010;
      end
    end else begin
      eA = a; eS = s; eF = fl;
      if (fl[1] != ob) begin
        eFault = 1'b1; eCode = 3'd4; eFA = a;
      end else if (s != 0 && (a[3:0] != 0 || s[3:0] != 0)) begin
        eFault = 1'b1; eCode = 3'd1; eFA = ob ? a : a + s;
      end else begin
        if (ob) left = ($signed(s) > 0) ? int'(s >> 4) : 0;
        else    left = ($signed(s) < 0) ? int'((-s) >> 4) : 0;
        if (stg == 2'd1 && left > BUDGET) left = BUDGET;
        for (int i = 0; i < left; i++) begin
          wa = ob ? eA : eA + eS;
          expWA[eN] = wa;
          eN++;
          if (i == errAt) begin
            eFault = 1'b1; eCode = errKind[0] ? 3'd2 : 3'd3; eFA = wa;
            break;
          end
          if (ob) begin eA = eA + 16; eS = eS - 16; end
          else    eS = eS + 16;
        end
      end
    end
    // drive the command
    @(negedge clk);
    stageSel = stg; addrIn = a; sizeIn = s; algoB = ob; flagsIn = fl;
    fillByte = fillByte + 8'h3B;
    curErrAt = errAt; curErrKind = errKind; wN = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R12", "busy after start", 128'(busy), 128'd1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, req, "stage completes", 128'(done), 128'd1);
    chk(addrOut === eA, req, "addrOut", 128'(addrOut), 128'(eA));
    chk(sizeOut === eS, req, "sizeOut", 128'(sizeOut), 128'(eS));
    chk(flagsOut === eF, (stg == 2'd0) ? req : "R12", "flagsOut", 128'(flagsOut), 128'(eF));
    chk(fault === eFault, req, "fault", 128'(fault), 128'(eFault));
    chk(faultCode === eCode, req, "faultCode", 128'(faultCode), 128'(eCode));
    if (eFault)
      chk(faultAddr === eFA, req, "faultAddr", 128'(faultAddr), 128'(eFA));
    chk(wN == eN, "R10", "write count", 128'(wN), 128'(eN));
    wOk = 1'b1;
    for (int i = 0; i < eN && i < wN && i < 64; i++) begin
      if (wA[i] !== expWA[i] || wD[i] !== {16{fillByte}} || wT[i] !== expWA[i][27:24])
        wOk = 1'b0;
    end
    chk(wOk, "R1", "write address/data/tag", 128'(wN > 0 ? wA[0] : 32'd0),
        128'(eN > 0 ? expWA[0] : 32'd0));
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] base, rA, rS;
    logic [3:0]  rF;
    rstN = 1'b0; start = 1'b0; stageSel = 2'd0; algoB = 1'b0;
    addrIn = '0; sizeIn = '0; fillByte = 8'h11; flagsIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R12", "idle after reset", 128'({busy, done}), 128'd0);
    chk(wrValid === 1'b0 && fault === 1'b0, "R12", "no request or fault after reset",
        128'({wrValid, fault}), 128'd0);

    // full three-stage sweep, both algorithms, sizes 0..9 granules
    for (int ob = 0; ob < 2; ob++) begin
      for (int g = 0; g < 10; g++) begin
        readyMode = g % 2;
        base = (32'(g) << 24) | 32'h0000_4000 | (32'(ob) << 12);
        runOp(2'd0, base, 32'(g * 16), ob[0], 4'b1101, -1, 2'b00, "R4");
        rA = addrOut; rS = sizeOut; rF = flagsOut;
        runOp(2'd1, rA, rS, ob[0], rF, -1, 2'b00, "R6");
        rA = addrOut; rS = sizeOut; rF = flagsOut;
        runOp(2'd2, rA, rS, ob[0], rF, -1, 2'b00, "R5");
        chk(sizeOut === 32'd0, "R5", "size drained", 128'(sizeOut), 128'd0);
        chk(addrOut === base + 32'(g * 16), "R5", "final address",
            128'(addrOut), 128'(base + 32'(g * 16)));
      end
    end
    readyMode = 0;

    // clamp and stage code 3
    runOp(2'd0, 32'h0200_0000, 32'hFFFF_FFF0, 1'b1, 4'b1000, -1, 2'b00, "R2");
    runOp(2'd0, 32'h0200_0000, 32'hFFFF_FFF0, 1'b0, 4'b1000, -1, 2'b00, "R2");
    runOp(2'd3, 32'h0700_0000, 32'd96, 1'b1, 4'b0010, -1, 2'b00, "R2");
    runOp(2'd1, 32'h0600_0000, 32'd160, 1'b1, 4'b0010, -1, 2'b00, "R6");

    // prologue alignment
    runOp(2'd0, 32'h0100_2004, 32'd32, 1'b0, 4'b0110, -1, 2'b00, "R3");
    runOp(2'd0, 32'h0100_2000, 32'd24, 1'b1, 4'b0110, -1, 2'b00, "R3");

    // carry mismatch
    runOp(2'd1, 32'h0100_0000, 32'd32, 1'b1, 4'b0000, -1, 2'b00, "R7");
    runOp(2'd2, 32'h0100_0040, 32'hFFFF_FFE0, 1'b0, 4'b0010, -1, 2'b00, "R7");

    // main/epilogue alignment
    runOp(2'd1, 32'h0100_1000, 32'hFFFF_FFD8, 1'b0, 4'b0000, -1, 2'b00, "R8");
    runOp(2'd2, 32'h0100_1004, 32'd32, 1'b1, 4'b0010, -1, 2'b00, "R8");

    // zero or wrong-sign sizes
    runOp(2'd0, 32'h0100_3007, 32'd0, 1'b0, 4'b0000, -1, 2'b00, "R11");
    runOp(2'd1, 32'h0100_3007, 32'd0, 1'b1, 4'b0010, -1, 2'b00, "R11");
    runOp(2'd2, 32'h0100_3000, 32'd48, 1'b0, 4'b0000, -1, 2'b00, "R11");

    // memory errors at several positions, then resume
    for (int k = 0; k < 4; k++) begin
      for (int kind = 1; kind < 4; kind++) begin
        readyMode = kind % 2;
        runOp(2'd1, 32'h0300_8000, 32'd64, 1'b1, 4'b0010, k, 2'(kind), "R9");
        rA = addrOut; rS = sizeOut; rF = flagsOut;
        runOp(2'd2, rA, rS, 1'b1, rF, -1, 2'b00, "R9");
        runOp(2'd1, 32'h0500_9050, 32'hFFFF_FFB0, 1'b0, 4'b0000, k, 2'(kind), "R9");
        rA = addrOut; rS = sizeOut; rF = flagsOut;
        runOp(2'd2, rA, rS, 1'b0, rF, -1, 2'b00, "R9");
        chk(sizeOut === 32'd0, "R9", "resume drains size", 128'(sizeOut), 128'd0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule